// File: doc/BRIEF.md
# Program Counter with Return Stack

This block produces the instruction fetch address for a small processor core whose instructions are 14 bits wide. It holds a 13-bit program counter. Each cycle the counter either steps forward by one, takes a jump target, takes a call target, returns to a saved address or goes to the fixed interrupt vector. An eight-entry hardware stack keeps the return addresses that calls and interrupts save and that returns take back.

The counter spans an 8K-word space, but only the lowest 1K words of program memory exist. The fetch address is therefore the low ten bits of the counter, so any counter value above 03FFh reads an aliased location inside the first 1K.

The stack is circular and has no overflow or underflow flags. The instruction decoder drives the control strobes. The decoder is also responsible for discarding the prefetched word after a control transfer, which gives branches their two-cycle cost. The stall input freezes the whole block.

Top module: `fetch_pc_unit`

## Requirements
- R1: While reset is asserted and after it is released, the counter and the fetch address are 0000h. The stack pointer is empty and every stack entry is zero, so a return issued straight after reset sends the counter to 0000h.
- R2: With only advance asserted, the counter increases by one on each clock. From 1FFFh it wraps to 0000h.
- R3: A jump loads the full 13-bit target into the counter on the next clock and leaves the stack unchanged.
- R4: A call loads the target into the counter and pushes the counter value plus one. A later return resumes at that pushed address.
- R5: An interrupt acknowledge forces the counter to 0004h and pushes the counter value plus one.
- R6: A return loads the most recently pushed entry that has not yet been popped. Nested calls unwind in last-in, first-out order.
- R7: The stack holds eight entries in a ring. A ninth push overwrites the oldest entry. Popping past empty returns whatever the slot below the pointer holds, and no flag is raised.
- R8: While stall is asserted, the counter and the stack stay unchanged whatever other strobes are active.
- R9: Strobe priority, from highest to lowest, is stall, interrupt acknowledge, return, call, jump, advance. With no strobe active the counter holds.
- R10: The fetch address equals the low 10 bits of the counter. For example, a counter value of 1234h fetches 234h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Step to the next sequential instruction |
| jump_i | input | 1 | Load the target without saving a return address |
| call_i | input | 1 | Load the target and push the return address |
| ret_i | input | 1 | Pop the return address into the counter |
| irq_ack_i | input | 1 | Go to the interrupt vector and push the return address |
| stall_i | input | 1 | Freeze the counter and the stack |
| target_i | input | 13 | Jump or call destination |
| fetch_addr_o | output | 10 | Address presented to program memory |
| pc_o | output | 13 | Current program counter |

## Verification
A wrong stack pointer or a corrupted stack entry shows nothing at the ports until the next return. At that return, the counter takes the wrong value on the following clock. The tests therefore pair every push with a return that is checked one clock later, and that includes the wrap past eight entries and the pop past empty. Errors in the counter itself, such as a bad increment, a wrong target or a stall that leaks, show on pc_o and fetch_addr_o one clock after the strobe.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_JUMP,
        OP_CALL,
        OP_RET,
        OP_IRQ
    } pc_op_e;
endpackage

// File: rtl/pc_op_decode.sv
module pc_op_decode
    import fetch_pc_pkg::*;
(
    input  logic   adv_i,
    input  logic   jump_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   irq_ack_i,
    input  logic   stall_i,
    output pc_op_e op_o,
    output logic   push_o,
    output logic   pop_o
);
    // Fixed priority: stall, interrupt, return, call, jump, advance.
    always_comb begin
        if (stall_i)        op_o = OP_HOLD;
        else if (irq_ack_i) op_o = OP_IRQ;
        else if (ret_i)     op_o = OP_RET;
        else if (call_i)    op_o = OP_CALL;
        else if (jump_i)    op_o = OP_JUMP;
        else if (adv_i)     op_o = OP_INC;
        else                op_o = OP_HOLD;
        push_o = (op_o == OP_CALL) || (op_o == OP_IRQ);
        pop_o  = (op_o == OP_RET);
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int DATA_W = 13,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]                  ptr;
        logic [DEPTH-1:0][DATA_W-1:0]      slots;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    always_comb begin
        ptr_inc = (st_q.ptr == LAST) ? '0 : st_q.ptr + PTR_W'(1);
        ptr_dec = (st_q.ptr == '0) ? LAST : st_q.ptr - PTR_W'(1);
        top_o   = st_q.slots[ptr_dec];
        st_d    = st_q;
        if (push_i) begin
            st_d.slots[st_q.ptr] = push_data_i;
            st_d.ptr             = ptr_inc;
        end else if (pop_i) begin
            st_d.ptr = ptr_dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pc_pkg::*;
#(
    parameter int          PC_W    = 13,
    parameter int          FETCH_W = 10,
    parameter int          DEPTH   = 8,
    parameter logic [12:0] RST_VEC = 13'h0000,
    parameter logic [12:0] IRQ_VEC = 13'h0004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic               jump_i,
    input  logic               call_i,
    input  logic               ret_i,
    input  logic               irq_ack_i,
    input  logic               stall_i,
    input  logic [PC_W-1:0]    target_i,
    output logic [FETCH_W-1:0] fetch_addr_o,
    output logic [PC_W-1:0]    pc_o
);
    localparam logic [PC_W-1:0] RST_PC = PC_W'(RST_VEC);
    localparam logic [PC_W-1:0] IRQ_PC = PC_W'(IRQ_VEC);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t       st_d, st_q;
    pc_op_e          op;
    logic            push, pop;
    logic [PC_W-1:0] pc_plus1, stack_top;

    pc_op_decode u_dec (
        .adv_i    (adv_i),
        .jump_i   (jump_i),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .irq_ack_i(irq_ack_i),
        .stall_i  (stall_i),
        .op_o     (op),
        .push_o   (push),
        .pop_o    (pop)
    );

    ret_stack #(.DATA_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_data_i(pc_plus1),
        .top_o      (stack_top)
    );

    always_comb begin
        pc_plus1 = st_q.pc + PC_W'(1);
        st_d     = st_q;
        unique case (op)
            OP_INC:            st_d.pc = pc_plus1;
            OP_JUMP, OP_CALL:  st_d.pc = target_i;
            OP_RET:            st_d.pc = stack_top;
            OP_IRQ:            st_d.pc = IRQ_PC;
            default:           st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.pc <= RST_PC;
        else        st_q    <= st_d;
    end

    // Only the low 1K words exist; higher counter values alias into them.
    assign fetch_addr_o = st_q.pc[FETCH_W-1:0];
    assign pc_o         = st_q.pc;
endmodule

// File: rtl/fetch_pc_unit_chk.sv
module fetch_pc_unit_chk #(
    parameter int PC_W    = 13,
    parameter int FETCH_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adv_i,
    input logic               jump_i,
    input logic               call_i,
    input logic               ret_i,
    input logic               irq_ack_i,
    input logic               stall_i,
    input logic [PC_W-1:0]    target_i,
    input logic [FETCH_W-1:0] fetch_addr_o,
    input logic [PC_W-1:0]    pc_o
);
    logic none_active;
    assign none_active = !(adv_i || jump_i || call_i || ret_i || irq_ack_i || stall_i);

    a_r1_reset_pc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_o == '0));

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !jump_i && !call_i && !ret_i && !irq_ack_i && !stall_i)
        |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1))));

    a_r3_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !call_i && !ret_i && !irq_ack_i && !stall_i)
        |=> (pc_o == $past(target_i)));

    a_r5_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !stall_i) |=> (pc_o == PC_W'(4)));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(pc_o));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        none_active |=> $stable(pc_o));
endmodule

bind fetch_pc_unit fetch_pc_unit_chk #(.PC_W(PC_W), .FETCH_W(FETCH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (adv_i),
    .jump_i      (jump_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .irq_ack_i   (irq_ack_i),
    .stall_i     (stall_i),
    .target_i    (target_i),
    .fetch_addr_o(fetch_addr_o),
    .pc_o        (pc_o)
);

// File: tb/fetch_pc_unit_bench.sv
module fetch_pc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_i = 1'b0, jump_i = 1'b0, call_i = 1'b0;
    logic        ret_i = 1'b0, irq_ack_i = 1'b0, stall_i = 1'b0;
    logic [12:0] target_i = '0;
    logic [9:0]  fetch_addr_o;
    logic [12:0] pc_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fetch_pc_unit u_fetch_pc_unit (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .irq_ack_i(irq_ack_i),
        .stall_i(stall_i), .target_i(target_i),
        .fetch_addr_o(fetch_addr_o), .pc_o(pc_o)
    );

    task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cycle of strobes; outputs are sampled 1 ns after the edge.
    task automatic cyc(input logic a, input logic j, input logic c, input logic r,
                       input logic i, input logic s, input logic [12:0] t);
        adv_i = a; jump_i = j; call_i = c; ret_i = r; irq_ack_i = i; stall_i = s;
        target_i = t;
        @(posedge clk); #1;
        adv_i = 0; jump_i = 0; call_i = 0; ret_i = 0; irq_ack_i = 0; stall_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 pc in reset", pc_o, 13'h0000);
        chk("R1 fetch in reset", {3'b0, fetch_addr_o}, 13'h0000);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic t_reset_pop();
        do_reset();
        cyc(0,0,0,1,0,0,'0);
        chk("R1 pop after reset", pc_o, 13'h0000);
    endtask

    task automatic t_advance();
        do_reset();
        cyc(1,0,0,0,0,0,'0);
        chk("R2 step 1", pc_o, 13'h0001);
        cyc(1,0,0,0,0,0,'0);
        chk("R2 step 2", pc_o, 13'h0002);
        cyc(0,1,0,0,0,0,13'h1FFF);
        chk("R3 jump to top", pc_o, 13'h1FFF);
        cyc(1,0,0,0,0,0,'0);
        chk("R2 wrap", pc_o, 13'h0000);
    endtask

    task automatic t_call_ret();
        do_reset();
        cyc(0,1,0,0,0,0,13'h0040);
        cyc(0,0,1,0,0,0,13'h0200);
        chk("R4 call target", pc_o, 13'h0200);
        cyc(1,0,0,0,0,0,'0);
        cyc(0,0,1,0,0,0,13'h0300);
        chk("R4 nested call", pc_o, 13'h0300);
        cyc(0,0,0,1,0,0,'0);
        chk("R6 inner return", pc_o, 13'h0202);
        cyc(0,0,0,1,0,0,'0);
        chk("R6 outer return", pc_o, 13'h0041);
    endtask

    task automatic t_irq();
        do_reset();
        cyc(0,1,0,0,0,0,13'h0123);
        cyc(0,0,0,0,1,0,'0);
        chk("R5 irq vector", pc_o, 13'h0004);
        cyc(0,0,0,1,0,0,'0);
        chk("R5 irq return", pc_o, 13'h0124);
    endtask

    task automatic t_ring();
        logic [12:0] pushed [9];
        logic [12:0] here;
        do_reset();
        cyc(0,1,0,0,0,0,13'h0100);
        here = 13'h0100;
        for (int k = 0; k < 9; k++) begin
            pushed[k] = here + 13'd1;
            here = 13'h0800 + 13'(k * 16);
            cyc(0,0,1,0,0,0,here);
        end
        for (int k = 0; k < 8; k++) begin
            cyc(0,0,0,1,0,0,'0);
            chk("R7 ring pop", pc_o, pushed[8-k]);
        end
        cyc(0,0,0,1,0,0,'0);
        chk("R7 pop past empty", pc_o, pushed[8]);
    endtask

    task automatic t_stall();
        do_reset();
        cyc(0,1,0,0,0,0,13'h0050);
        cyc(0,0,1,0,0,0,13'h0300);
        cyc(1,0,1,0,0,1,13'h0400);
        chk("R8 stall blocks call", pc_o, 13'h0300);
        cyc(0,0,0,1,1,1,'0);
        chk("R8 stall blocks irq/ret", pc_o, 13'h0300);
        cyc(0,0,0,1,0,0,'0);
        chk("R8 stack untouched", pc_o, 13'h0051);
    endtask

    task automatic t_priority();
        do_reset();
        cyc(0,1,0,0,0,0,13'h0010);
        cyc(0,0,1,0,0,0,13'h0020);
        cyc(0,0,1,1,0,0,13'h0555);
        chk("R9 ret over call", pc_o, 13'h0011);
        cyc(0,0,1,1,1,0,13'h0555);
        chk("R9 irq over ret", pc_o, 13'h0004);
        cyc(0,1,1,0,0,0,13'h0600);
        chk("R9 call over jump", pc_o, 13'h0600);
        cyc(0,0,0,1,0,0,'0);
        chk("R9 call pushed", pc_o, 13'h0005);
        cyc(1,1,0,0,0,0,13'h0700);
        chk("R9 jump over advance", pc_o, 13'h0700);
        cyc(0,0,0,0,0,0,'0);
        chk("R9 idle hold", pc_o, 13'h0700);
    endtask

    task automatic t_alias();
        do_reset();
        cyc(0,1,0,0,0,0,13'h1234);
        chk("R10 pc full", pc_o, 13'h1234);
        chk("R10 fetch alias", {3'b0, fetch_addr_o}, 13'h0234);
        cyc(0,1,0,0,0,0,13'h03FF);
        cyc(1,0,0,0,0,0,'0);
        chk("R10 fetch above 1K", {3'b0, fetch_addr_o}, 13'h0000);
        chk("R10 pc above 1K", pc_o, 13'h0400);
    endtask

    initial begin
        #2;
        t_reset_pop();
        t_advance();
        t_call_ret();
        t_irq();
        t_ring();
        t_stall();
        t_priority();
        t_alias();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule